// File: doc/BRIEF.md
# Partitioned Vector Lane Sequencer

This block drives the per-element control of a vector unit with eight parallel lanes. The lanes can be divided into equal groups: one group of eight, two of four, four of two, or eight single lanes. Each group runs its own thread and steps through its own vector instruction, independently of the other groups. Within a group, every lane follows the same control in each cycle, and each lane handles one element of the instruction. Elements are dealt to the lanes of the group in rotation.

Each group has a slot. A slot holds an accept handshake that carries a vector length and an opcode tag. The slot reports busy while its instruction runs and gives a done pulse when the instruction ends. Each cycle, every lane shows four things: whether it holds a live element, which thread owns it, the element index and the opcode.

A partition change is taken only while no group is running. A change requested while a group is busy is dropped and sets an error flag that stays set until reset.

Each group slot runs a state machine with three states:
- `G_IDLE`: waiting for an instruction.
- `G_RUN`: one element step per cycle.
- `G_DONE`: the single done cycle, in which the slot can also accept.

The transitions are:
- IDLE to RUN on accept.
- RUN to RUN while elements remain.
- RUN to DONE on the final step.
- DONE to RUN on accept.
- DONE to IDLE otherwise.

The partition controller has two states, `CFG_CLEAN` and `CFG_FAULT`. It moves from CLEAN to FAULT on a rejected change, and FAULT is never left except by reset.

Top module: `vlane_seq`

## Requirements
- R1: After reset the partition is one group of eight lanes, `grp_ready` is 8'b0000_0001, no slot is busy or done, no lane is valid, every `lane_tid` is 0 and `cfg_err` is 0.
- R2: The `cfg_mode` encoding is: 0 gives 1 group of 8 lanes, 1 gives 2 groups of 4, 2 gives 4 groups of 2, and 3 gives 8 groups of 1.
  - Group g owns the contiguous lanes g*S to g*S+S-1, where S is the group size, and those lanes drive `lane_tid` = g.
  - Slots numbered at or above the group count keep ready low, and their `grp_valid` has no effect.
- R3: In step k of an instruction, counting from 0, the lane at position p of its group carries element index k*S+p.
- R4: An accepted instruction holds its slot busy for max(1, ceil(VL/S)) cycles, starting in the cycle after acceptance. For example, VL=64 on one group of 8 takes exactly 8 cycles.
- R5: A lane whose element index would be at or beyond VL is driven invalid. An invalid lane drives index 0 and opcode 0.
- R6: A vector length of 0 is accepted. The slot is busy for one cycle with no lane valid, then pulses done.
- R7: Ready is high only for an active slot that is not busy. An instruction is taken when valid and ready are both high and `cfg_write` is low. A new instruction can be taken in the same cycle that done is high.
- R8: Done is high for exactly one cycle, the cycle right after the final element step.
- R9: Valid lanes carry the opcode captured at acceptance. Groups run concurrently with different lengths and do not affect each other.
- R10: A `cfg_write` while no slot is busy applies `cfg_mode` from the next cycle on. An instruction offered in that same cycle is not taken.
- R11: A `cfg_write` while any slot is busy leaves the partition unchanged and sets `cfg_err`, which stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_write | input | 1 | Request a partition change |
| cfg_mode | input | 2 | Requested partition (0..3 = 1, 2, 4, 8 groups) |
| grp_valid | input | 8 | Per-slot instruction offer |
| grp_vl | input | 64 | Per-slot vector length, 8 bits per slot |
| grp_op | input | 32 | Per-slot opcode tag, 4 bits per slot |
| grp_ready | output | 8 | Per-slot ready to accept |
| grp_busy | output | 8 | Per-slot instruction running |
| grp_done | output | 8 | Per-slot one-cycle completion pulse |
| cfg_err | output | 1 | Sticky rejected-change flag |
| lane_valid | output | 8 | Lane carries a live element |
| lane_tid | output | 24 | Owning thread per lane, 3 bits per lane |
| lane_idx | output | 64 | Element index per lane, 8 bits per lane |
| lane_op | output | 32 | Opcode per lane, 4 bits per lane |

## Verification
The assertions check the following on every cycle:
- Ready and busy are never high together.
- An accepted offer always leads to busy.
- Done lasts one cycle and always follows a busy cycle.
- A valid lane always belongs to a busy group.
- An invalid lane drives index and opcode to zero.
- A change requested while busy always leaves the error flag set, and the flag stays set.

Only the bench scenarios can show the rest:
- That element indices follow the rotation pattern under each partition.
- That cycle counts match the rounded-up formula.
- That tails are masked at the right element.
- That concurrent groups keep their own opcodes and lengths.
- That a rejected or same-cycle change leaves the lane-to-thread mapping as required.

// File: rtl/vls_pkg.sv
package vls_pkg;

    // Per-slot sequencing state
    typedef enum logic [1:0] {
        G_IDLE = 2'd0,
        G_RUN  = 2'd1,
        G_DONE = 2'd2
    } grp_state_e;

    // Partition controller error state
    typedef enum logic {
        CFG_CLEAN = 1'b0,
        CFG_FAULT = 1'b1
    } cfg_state_e;

endpackage

// File: rtl/vls_part_ctrl.sv
module vls_part_ctrl #(
    parameter int NUM_LANES = 8,
    parameter int LOG_L     = 3,
    parameter int MODE_W    = 2,
    parameter int GS_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_write,
    input  logic [MODE_W-1:0] cfg_mode,
    input  logic              any_busy,
    output logic [MODE_W-1:0] part_mode,
    output logic [GS_W-1:0]   grp_size,
    output logic              cfg_err
);
    import vls_pkg::*;

    cfg_state_e        state_q, state_d;
    logic [MODE_W-1:0] mode_q;
    logic              legal;
    logic              apply;

    assign legal = (cfg_mode <= MODE_W'(LOG_L));
    assign apply = cfg_write && !any_busy && legal;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CFG_CLEAN: if (cfg_write && (any_busy || !legal)) state_d = CFG_FAULT;
            CFG_FAULT: state_d = CFG_FAULT;
            default:   state_d = CFG_CLEAN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CFG_CLEAN;
            mode_q  <= '0;
        end else begin
            state_q <= state_d;
            if (apply) mode_q <= cfg_mode;
        end
    end

    always_comb begin
        part_mode = mode_q;
        grp_size  = GS_W'(NUM_LANES) >> mode_q;
        cfg_err   = (state_q == CFG_FAULT);
    end

endmodule

// File: rtl/vls_group_fsm.sv
module vls_group_fsm #(
    parameter int VL_W = 8,
    parameter int OP_W = 4,
    parameter int GS_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            slot_active,
    input  logic            hold,
    input  logic [GS_W-1:0] grp_size,
    input  logic            in_valid,
    input  logic [VL_W-1:0] in_vl,
    input  logic [OP_W-1:0] in_op,
    output logic            ready,
    output logic            busy,
    output logic            done,
    output logic [VL_W:0]   run_base,
    output logic [VL_W-1:0] run_vl,
    output logic [OP_W-1:0] run_op
);
    import vls_pkg::*;

    localparam int BW = VL_W + 1;

    grp_state_e      state_q, state_d;
    logic [BW-1:0]   base_q;
    logic [VL_W-1:0] vl_q;
    logic [OP_W-1:0] op_q;
    logic [BW-1:0]   step;
    logic            last;
    logic            accept;

    assign step   = base_q + BW'(grp_size);
    assign last   = (step >= {1'b0, vl_q});
    assign accept = in_valid && ready && !hold;

    // next-state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            G_IDLE:  if (accept) state_d = G_RUN;
            G_RUN:   if (last)   state_d = G_DONE;
            G_DONE:  state_d = accept ? G_RUN : G_IDLE;
            default: state_d = G_IDLE;
        endcase
    end

    // state and instruction registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= G_IDLE;
            base_q  <= '0;
            vl_q    <= '0;
            op_q    <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                base_q <= '0;
                vl_q   <= in_vl;
                op_q   <= in_op;
            end else if (state_q == G_RUN && !last) begin
                base_q <= step;
            end
        end
    end

    // outputs
    always_comb begin
        ready = 1'b0;
        busy  = 1'b0;
        done  = 1'b0;
        unique case (state_q)
            G_IDLE:  ready = slot_active;
            G_RUN:   busy  = 1'b1;
            G_DONE: begin
                ready = slot_active;
                done  = 1'b1;
            end
            default: ready = 1'b0;
        endcase
        run_base = base_q;
        run_vl   = vl_q;
        run_op   = op_q;
    end

endmodule

// File: rtl/vls_lane_map.sv
module vls_lane_map #(
    parameter int NUM_LANES = 8,
    parameter int LOG_L     = 3,
    parameter int MODE_W    = 2,
    parameter int TID_W     = 3,
    parameter int VL_W      = 8,
    parameter int OP_W      = 4
) (
    input  logic [MODE_W-1:0]                 part_mode,
    input  logic [NUM_LANES-1:0]              grp_run,
    input  logic [NUM_LANES-1:0][VL_W:0]      grp_base,
    input  logic [NUM_LANES-1:0][VL_W-1:0]    grp_vl,
    input  logic [NUM_LANES-1:0][OP_W-1:0]    grp_op,
    output logic [NUM_LANES-1:0]              lane_valid,
    output logic [NUM_LANES-1:0][TID_W-1:0]   lane_tid,
    output logic [NUM_LANES-1:0][VL_W-1:0]    lane_idx,
    output logic [NUM_LANES-1:0][OP_W-1:0]    lane_op
);

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        localparam logic [TID_W-1:0] LANE_ID = TID_W'(l);

        logic [MODE_W-1:0] shamt;
        logic [TID_W-1:0]  grp;
        logic [TID_W-1:0]  pos;
        logic [VL_W:0]     elem;
        logic              live;

        always_comb begin
            shamt = MODE_W'(LOG_L) - part_mode;
            grp   = LANE_ID >> shamt;
            pos   = LANE_ID & ~({TID_W{1'b1}} << shamt);
            elem  = grp_base[grp] + {{(VL_W + 1 - TID_W){1'b0}}, pos};
            live  = grp_run[grp] && (elem < {1'b0, grp_vl[grp]});
            lane_valid[l] = live;
            lane_tid[l]   = grp;
            lane_idx[l]   = live ? elem[VL_W-1:0] : '0;
            lane_op[l]    = live ? grp_op[grp] : '0;
        end
    end

endmodule

// File: rtl/vlane_seq.sv
module vlane_seq #(
    parameter  int NUM_LANES = 8,
    parameter  int VL_W      = 8,
    parameter  int OP_W      = 4,
    localparam int LOG_L     = $clog2(NUM_LANES),
    localparam int MODE_W    = $clog2(LOG_L + 1),
    localparam int TID_W     = LOG_L,
    localparam int GS_W      = LOG_L + 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_write,
    input  logic [MODE_W-1:0]           cfg_mode,
    input  logic [NUM_LANES-1:0]        grp_valid,
    input  logic [NUM_LANES*VL_W-1:0]   grp_vl,
    input  logic [NUM_LANES*OP_W-1:0]   grp_op,
    output logic [NUM_LANES-1:0]        grp_ready,
    output logic [NUM_LANES-1:0]        grp_busy,
    output logic [NUM_LANES-1:0]        grp_done,
    output logic                        cfg_err,
    output logic [NUM_LANES-1:0]        lane_valid,
    output logic [NUM_LANES*TID_W-1:0]  lane_tid,
    output logic [NUM_LANES*VL_W-1:0]   lane_idx,
    output logic [NUM_LANES*OP_W-1:0]   lane_op
);

    logic [MODE_W-1:0]                part_mode;
    logic [GS_W-1:0]                  grp_size;
    logic [NUM_LANES-1:0]             slot_act;
    logic [NUM_LANES-1:0][VL_W:0]     run_base;
    logic [NUM_LANES-1:0][VL_W-1:0]   run_vl;
    logic [NUM_LANES-1:0][OP_W-1:0]   run_op;
    logic [NUM_LANES-1:0][TID_W-1:0]  map_tid;
    logic [NUM_LANES-1:0][VL_W-1:0]   map_idx;
    logic [NUM_LANES-1:0][OP_W-1:0]   map_op;

    vls_part_ctrl #(
        .NUM_LANES (NUM_LANES),
        .LOG_L     (LOG_L),
        .MODE_W    (MODE_W),
        .GS_W      (GS_W)
    ) i_part (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_write (cfg_write),
        .cfg_mode  (cfg_mode),
        .any_busy  (|grp_busy),
        .part_mode (part_mode),
        .grp_size  (grp_size),
        .cfg_err   (cfg_err)
    );

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_slot
        localparam logic [TID_W-1:0] SLOT_ID = TID_W'(g);

        assign slot_act[g] = ((SLOT_ID >> part_mode) == '0);

        vls_group_fsm #(
            .VL_W (VL_W),
            .OP_W (OP_W),
            .GS_W (GS_W)
        ) i_grp (
            .clk         (clk),
            .rst_n       (rst_n),
            .slot_active (slot_act[g]),
            .hold        (cfg_write),
            .grp_size    (grp_size),
            .in_valid    (grp_valid[g]),
            .in_vl       (grp_vl[g*VL_W +: VL_W]),
            .in_op       (grp_op[g*OP_W +: OP_W]),
            .ready       (grp_ready[g]),
            .busy        (grp_busy[g]),
            .done        (grp_done[g]),
            .run_base    (run_base[g]),
            .run_vl      (run_vl[g]),
            .run_op      (run_op[g])
        );
    end

    vls_lane_map #(
        .NUM_LANES (NUM_LANES),
        .LOG_L     (LOG_L),
        .MODE_W    (MODE_W),
        .TID_W     (TID_W),
        .VL_W      (VL_W),
        .OP_W      (OP_W)
    ) i_map (
        .part_mode  (part_mode),
        .grp_run    (grp_busy),
        .grp_base   (run_base),
        .grp_vl     (run_vl),
        .grp_op     (run_op),
        .lane_valid (lane_valid),
        .lane_tid   (map_tid),
        .lane_idx   (map_idx),
        .lane_op    (map_op)
    );

    assign lane_tid = map_tid;
    assign lane_idx = map_idx;
    assign lane_op  = map_op;

endmodule

// File: rtl/vls_checker.sv
module vls_checker #(
    parameter int NUM_LANES = 8,
    parameter int VL_W      = 8,
    parameter int OP_W      = 4,
    parameter int MODE_W    = 2,
    parameter int TID_W     = 3
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        cfg_write,
    input logic [MODE_W-1:0]           cfg_mode,
    input logic [NUM_LANES-1:0]        grp_valid,
    input logic [NUM_LANES-1:0]        grp_ready,
    input logic [NUM_LANES-1:0]        grp_busy,
    input logic [NUM_LANES-1:0]        grp_done,
    input logic                        cfg_err,
    input logic [NUM_LANES-1:0]        lane_valid,
    input logic [NUM_LANES*TID_W-1:0]  lane_tid,
    input logic [NUM_LANES*VL_W-1:0]   lane_idx,
    input logic [NUM_LANES*OP_W-1:0]   lane_op
);

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err); // R11
    AST_BUSY_CHANGE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_write && (|grp_busy)) |=> cfg_err); // R11

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_slot_chk
        AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            !(grp_ready[g] && grp_busy[g])); // R7
        AST_ACCEPT_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
            (grp_valid[g] && grp_ready[g] && !cfg_write) |=> grp_busy[g]); // R7
        AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
            grp_done[g] |=> !grp_done[g]); // R8
        AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
            grp_done[g] |-> $past(grp_busy[g])); // R8
    end

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane_chk
        AST_LANE_OWNER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
            lane_valid[l] |-> grp_busy[lane_tid[l*TID_W +: TID_W]]); // R4
        AST_IDLE_LANE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            !lane_valid[l] |-> (lane_idx[l*VL_W +: VL_W] == '0 && lane_op[l*OP_W +: OP_W] == '0)); // R5
    end

endmodule

bind vlane_seq vls_checker #(
    .NUM_LANES (NUM_LANES),
    .VL_W      (VL_W),
    .OP_W      (OP_W),
    .MODE_W    (MODE_W),
    .TID_W     (TID_W)
) i_vls_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_write  (cfg_write),
    .cfg_mode   (cfg_mode),
    .grp_valid  (grp_valid),
    .grp_ready  (grp_ready),
    .grp_busy   (grp_busy),
    .grp_done   (grp_done),
    .cfg_err    (cfg_err),
    .lane_valid (lane_valid),
    .lane_tid   (lane_tid),
    .lane_idx   (lane_idx),
    .lane_op    (lane_op)
);

// File: tb/test_vlane_seq.sv
module test_vlane_seq;

    localparam int CLK_PERIOD = 10;
    localparam int NL  = 8;
    localparam int VLW = 8;
    localparam int OPW = 4;
    localparam int TW  = 3;
    localparam int NROWS = 7;
    // mode, vector length, opcode, expected busy cycles
    localparam int TBL [NROWS][4] = '{
        '{0, 64,  3, 8},
        '{0, 13,  5, 2},
        '{1,  9,  7, 3},
        '{2,  5,  2, 3},
        '{3,  3,  1, 3},
        '{0,  8, 15, 1},
        '{1,  4,  6, 1}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_write = 1'b0;
    logic [1:0]        cfg_mode = '0;
    logic [NL-1:0]     grp_valid = '0;
    logic [NL*VLW-1:0] grp_vl = '0;
    logic [NL*OPW-1:0] grp_op = '0;
    logic [NL-1:0]     grp_ready, grp_busy, grp_done, lane_valid;
    logic              cfg_err;
    logic [NL*TW-1:0]  lane_tid;
    logic [NL*VLW-1:0] lane_idx;
    logic [NL*OPW-1:0] lane_op;

    int checks = 0;
    int failures = 0;

    vlane_seq i_vlane_seq (
        .clk(clk), .rst_n(rst_n), .cfg_write(cfg_write), .cfg_mode(cfg_mode),
        .grp_valid(grp_valid), .grp_vl(grp_vl), .grp_op(grp_op),
        .grp_ready(grp_ready), .grp_busy(grp_busy), .grp_done(grp_done),
        .cfg_err(cfg_err), .lane_valid(lane_valid), .lane_tid(lane_tid),
        .lane_idx(lane_idx), .lane_op(lane_op)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int tid_of(input int l);
        return int'(lane_tid[l*TW +: TW]);
    endfunction
    function automatic int idx_of(input int l);
        return int'(lane_idx[l*VLW +: VLW]);
    endfunction
    function automatic int op_of(input int l);
        return int'(lane_op[l*OPW +: OPW]);
    endfunction

    // called at a negedge; leaves at the negedge where the new mode is visible
    task automatic set_mode(input int m);
        cfg_write = 1'b1;
        cfg_mode  = 2'(m);
        @(negedge clk);
        cfg_write = 1'b0;
        chk("R10", "ready mask after change", int'(grp_ready), (1 << (1 << m)) - 1);
    endtask

    // offer at the current negedge; returns at the negedge of step 0
    task automatic issue(input int g, input int vl, input int op);
        grp_valid[g] = 1'b1;
        grp_vl[g*VLW +: VLW] = 8'(vl);
        grp_op[g*OPW +: OPW] = 4'(op);
        @(negedge clk);
        grp_valid[g] = 1'b0;
    endtask

    // starts at step 0, ends at the done cycle
    task automatic run_check(input int g, input int m, input int vl, input int op, input int ncyc);
        int gs;
        gs = NL >> m;
        for (int k = 0; k < ncyc; k++) begin
            chk("R4", "busy during step", int'(grp_busy[g]), 1);
            chk("R8", "done low during step", int'(grp_done[g]), 0);
            for (int p = 0; p < gs; p++) begin
                int l, e;
                bit ev;
                l  = g * gs + p;
                e  = k * gs + p;
                ev = (e < vl);
                chk("R5", "lane valid", int'(lane_valid[l]), int'(ev));
                chk("R2", "lane thread", tid_of(l), g);
                chk("R3", "element index", idx_of(l), ev ? e : 0);
                chk("R9", "lane opcode", op_of(l), ev ? op : 0);
            end
            @(negedge clk);
        end
        chk("R8", "done pulse", int'(grp_done[g]), 1);
        chk("R4", "busy ended", int'(grp_busy[g]), 0);
        chk("R7", "ready in done cycle", int'(grp_ready[g]), 1);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL R1 watchdog actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "ready after reset", int'(grp_ready), 1);
        chk("R1", "busy after reset", int'(grp_busy), 0);
        chk("R1", "done after reset", int'(grp_done), 0);
        chk("R1", "lanes after reset", int'(lane_valid), 0);
        chk("R1", "tids after reset", int'(lane_tid), 0);
        chk("R1", "err after reset", int'(cfg_err), 0);

        // table walk: R2 R3 R4 R5 R9
        for (int i = 0; i < NROWS; i++) begin
            set_mode(TBL[i][0]);
            issue(0, TBL[i][1], TBL[i][2]);
            run_check(0, TBL[i][0], TBL[i][1], TBL[i][2], TBL[i][3]);
        end

        // R6 zero length
        set_mode(0);
        issue(0, 0, 5);
        run_check(0, 0, 0, 5, 1);

        // R7 back-to-back accept in the done cycle
        issue(0, 8, 1);
        run_check(0, 0, 8, 1, 1);
        issue(0, 16, 2);
        run_check(0, 0, 16, 2, 2);

        // R9 two concurrent groups
        set_mode(1);
        grp_valid[0] = 1'b1; grp_vl[0 +: VLW] = 8'd12; grp_op[0 +: OPW] = 4'd4;
        grp_valid[1] = 1'b1; grp_vl[VLW +: VLW] = 8'd4; grp_op[OPW +: OPW] = 4'd9;
        @(negedge clk);
        grp_valid = '0;
        chk("R9", "both busy", int'(grp_busy), 3);
        chk("R9", "group0 op", op_of(0), 4);
        chk("R9", "group1 op", op_of(4), 9);
        @(negedge clk);
        chk("R9", "group1 done", int'(grp_done[1]), 1);
        chk("R9", "group0 still busy", int'(grp_busy[0]), 1);
        chk("R9", "group1 lane idle", int'(lane_valid[4]), 0);
        chk("R3", "group0 lane1 index", idx_of(1), 5);
        @(negedge clk);
        chk("R5", "group0 tail lane3 index", idx_of(3), 11);
        chk("R8", "group1 done low", int'(grp_done[1]), 0);
        @(negedge clk);
        chk("R8", "group0 done", int'(grp_done[0]), 1);

        // R2 inactive slot ignores offers
        grp_valid[5] = 1'b1; grp_vl[5*VLW +: VLW] = 8'd4;
        @(negedge clk);
        grp_valid = '0;
        chk("R2", "inactive slot not busy", int'(grp_busy), 0);
        chk("R2", "no lanes from inactive slot", int'(lane_valid), 0);
        chk("R2", "ready mask two groups", int'(grp_ready), 3);

        // R10 change plus offer in the same cycle
        cfg_write = 1'b1; cfg_mode = 2'd2;
        grp_valid[0] = 1'b1; grp_vl[0 +: VLW] = 8'd4;
        @(negedge clk);
        cfg_write = 1'b0; grp_valid = '0;
        chk("R10", "offer not taken", int'(grp_busy), 0);
        chk("R10", "four groups ready", int'(grp_ready), 15);
        chk("R2", "lane5 thread in four groups", tid_of(5), 2);

        // R11 change while busy
        issue(0, 20, 7);
        cfg_write = 1'b1; cfg_mode = 2'd0;
        @(negedge clk);
        cfg_write = 1'b0;
        chk("R11", "err set", int'(cfg_err), 1);
        chk("R11", "ready mask kept", int'(grp_ready), 14);
        chk("R11", "lane2 thread kept", tid_of(2), 1);
        repeat (9) @(negedge clk);
        chk("R11", "done after 10 steps", int'(grp_done[0]), 1);
        set_mode(0);
        chk("R11", "err stays set", int'(cfg_err), 1);

        // R1 reset clears err
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "err cleared by reset", int'(cfg_err), 0);
        chk("R1", "single group after reset", int'(grp_ready), 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule